// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division, both signed and unsigned, and keeps its results in a private pair of 32-bit registers, HI and LO, rather than in a general register file. A command names only its two source operands and its kind. The unit computes one bit per clock over 32 cycles and then writes HI and LO implicitly. A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI.

The surrounding pipeline reads results through a move-from port and preloads or restores the pair through a move-to port. A move-from request that arrives while a computation runs raises a stall output, and the pipeline holds the request until the unit is idle. A move-to write always wins: it is stored at once, and any computation still running is abandoned so that the written value is not overwritten later.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy and stall are 0, and both HI and LO read as zero.
- R2: A command with op_kind 2'b00 (signed multiply) leaves the lower 32 bits of the two's-complement product of op_a and op_b in LO and the upper 32 bits in HI.
- R3: A command with op_kind 2'b01 (unsigned multiply) leaves the lower half of the unsigned 64-bit product in LO and the upper half in HI.
- R4: A command with op_kind 2'b10 (signed divide) of op_a by a non-zero op_b puts the quotient, rounded toward zero, in LO and the remainder, which has the sign of op_a, in HI. The case 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R5: A command with op_kind 2'b11 (unsigned divide) of op_a by a non-zero op_b puts the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A divide of either kind by zero raises no error and ends with LO = 0xFFFFFFFF and HI = op_a.
- R7: A command is accepted on a rising edge where op_valid is 1, busy is 0 and mt_req is 0. busy is then 1 for exactly 32 cycles, and HI/LO hold the result in the first cycle where busy is 0 again.
- R8: op_valid is ignored while busy is 1 and in any cycle where mt_req is 1. The running result is unchanged, and no new computation starts.
- R9: mf_data shows HI when mf_sel is 1 and LO when mf_sel is 0. stall is 1 exactly when mf_req is 1 and busy is 1.
- R10: With mt_req set, the register chosen by mt_sel (1 = HI, 0 = LO) takes mt_data on that edge, and the other register keeps its value. If a computation was running, busy is 0 in the next cycle, and the computation never writes HI or LO afterwards.
- R11: HI and LO keep their values while a computation runs, until its completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command request |
| op_kind | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| mf_req | input | 1 | Move-from request |
| mf_sel | input | 1 | Move-from source: 1 HI, 0 LO |
| mf_data | output | 32 | Selected HI or LO value |
| stall | output | 1 | Move-from must wait |
| mt_req | input | 1 | Move-to write |
| mt_sel | input | 1 | Move-to target: 1 HI, 0 LO |
| mt_data | input | 32 | Value to write |

## Verification
The assertions assume that op_valid, mt_req and their data are steady around the rising edge, and that a move-from caller keeps its request until stall drops. They make no assumption about command spacing: a new command during a run, or a command alongside a move-to, is legal input and is checked to have no effect. The stimulus changes every input only on the falling edge. It draws random commands and operands, with extra weight on zero, all-ones and most-negative operands, and it also issues commands deliberately during a run and together with move-to writes.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_kind,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  input  logic         mf_req,
  input  logic         mf_sel,
  output logic [W-1:0] mf_data,
  output logic         stall,
  input  logic         mt_req,
  input  logic         mt_sel,
  input  logic [W-1:0] mt_data
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  hi_q, lo_q, mag_q, wlo_q, dvd_q;
  logic [W:0]    whi_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, div_q, negq_q, negr_q, dz_q;

  wire start = op_valid & ~busy_q & ~mt_req;
  wire sgn   = ~op_kind[0];
  wire a_neg = sgn & op_a[W-1];
  wire b_neg = sgn & op_b[W-1];
  wire [W-1:0] a_mag = a_neg ? -op_a : op_a;
  wire [W-1:0] b_mag = b_neg ? -op_b : op_b;
  wire last = busy_q && (cnt_q == CW'(W-1));

  logic [W:0]     msum, trial, nhi;
  logic [W-1:0]   nlo;
  logic           ge;
  logic [2*W-1:0] prod, prod_s;
  logic [W-1:0]   quo, rem, res_hi, res_lo;

  always_comb begin
    msum  = whi_q + (wlo_q[0] ? {1'b0, mag_q} : '0);
    trial = {whi_q[W-1:0], wlo_q[W-1]};
    ge    = trial >= {1'b0, mag_q};
    if (div_q) begin
      nhi = ge ? trial - {1'b0, mag_q} : trial;
      nlo = {wlo_q[W-2:0], ge};
    end else begin
      nhi = {1'b0, msum[W:1]};
      nlo = {msum[0], wlo_q[W-1:1]};
    end
    prod   = {nhi[W-1:0], nlo};
    prod_s = negq_q ? -prod : prod;
    quo    = negq_q ? -nlo : nlo;
    rem    = negr_q ? -nhi[W-1:0] : nhi[W-1:0];
    if (div_q) begin
      res_hi = dz_q ? dvd_q : rem;
      res_lo = dz_q ? '1 : quo;
    end else begin
      res_hi = prod_s[2*W-1:W];
      res_lo = prod_s[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; mag_q <= '0; wlo_q <= '0; dvd_q <= '0;
      whi_q <= '0; cnt_q <= '0; busy_q <= 1'b0; div_q <= 1'b0;
      negq_q <= 1'b0; negr_q <= 1'b0; dz_q <= 1'b0;
    end else if (mt_req) begin
      busy_q <= 1'b0;
      if (mt_sel) hi_q <= mt_data;
      else        lo_q <= mt_data;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      div_q  <= op_kind[1];
      negq_q <= a_neg ^ b_neg;
      negr_q <= a_neg;
      dz_q   <= op_kind[1] && (op_b == '0);
      dvd_q  <= op_a;
      whi_q  <= '0;
      wlo_q  <= op_kind[1] ? a_mag : b_mag;
      mag_q  <= op_kind[1] ? b_mag : a_mag;
    end else if (busy_q) begin
      whi_q <= nhi;
      wlo_q <= nlo;
      cnt_q <= cnt_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        hi_q   <= res_hi;
        lo_q   <= res_lo;
      end
    end
  end

  assign busy    = busy_q;
  assign stall   = mf_req & busy_q;
  assign mf_data = mf_sel ? hi_q : lo_q;

  p_start_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(op_valid) && !$past(mt_req));

  p_run_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mt_req && !last |=> busy_q && $stable(hi_q) && $stable(lo_q));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mt_req |=> $stable(mag_q) && $stable(dvd_q) && $stable(div_q));

  p_mt_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mt_req && mt_sel |=> !busy_q && hi_q == $past(mt_data) && $stable(lo_q));

  p_mt_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mt_req && !mt_sel |=> !busy_q && lo_q == $past(mt_data) && $stable(hi_q));

  p_divzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last && !mt_req && div_q && dz_q |=> lo_q == {W{1'b1}} && hi_q == $past(dvd_q));

  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy && mf_req);
endmodule

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, mf_req = 1'b0, mf_sel = 1'b0, mt_req = 1'b0, mt_sel = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [31:0] op_a = '0, op_b = '0, mt_data = '0;
  logic        busy, stall;
  logic [31:0] mf_data;
  int unsigned n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_a(op_a), .op_b(op_b), .busy(busy), .mf_req(mf_req), .mf_sel(mf_sel),
    .mf_data(mf_data), .stall(stall), .mt_req(mt_req), .mt_sel(mt_sel),
    .mt_data(mt_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    int sa, sb;
    sa = int'(a); sb = int'(b);
    case (k)
      2'b00: p = 64'(longint'(sa) * longint'(sb));
      2'b01: p = {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) p = {a, 32'hFFFF_FFFF};
        else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) p = {32'h0, 32'h8000_0000};
        else p = {32'(sa % sb), 32'(sa / sb)};
      end
      default: begin
        if (b == 0) p = {a, 32'hFFFF_FFFF};
        else p = {a % b, a / b};
      end
    endcase
    return p;
  endfunction

  function automatic string rtag(logic [1:0] k, logic [31:0] b);
    if (k[1] && b == 0) return "R6";
    case (k)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic start_op(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic read_hl(output logic [31:0] h, output logic [31:0] l);
    mf_sel = 1'b1; #1 h = mf_data;
    mf_sel = 1'b0; #1 l = mf_data;
  endtask

  task automatic full_op(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    logic [63:0] e;
    logic [31:0] h, l;
    int cyc;
    string t;
    e = model(k, a, b);
    t = rtag(k, b);
    start_op(k, a, b);
    wait_done(cyc);
    chk("R7 busy length", 32'(cyc), 32'd32);
    read_hl(h, l);
    chk({t, " HI"}, h, e[63:32]);
    chk({t, " LO"}, l, e[31:0]);
  endtask

  task automatic move_to(logic sel, logic [31:0] d);
    @(negedge clk);
    mt_req = 1'b1; mt_sel = sel; mt_data = d;
    @(negedge clk);
    mt_req = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] h, l, a, b;
    logic [63:0] e;
    logic [1:0]  k;
    int cyc;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    mf_req = 1'b1;
    read_hl(h, l);
    chk("R1 HI", h, 0); chk("R1 LO", l, 0);
    chk("R1 busy", 32'(busy), 0); chk("R1 stall", 32'(stall), 0);
    mf_req = 1'b0;

    // directed corners
    full_op(2'b00, 32'hFFFF_FFFF, 32'h0000_0007);
    full_op(2'b00, 32'h8000_0000, 32'h8000_0000);
    full_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    full_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002);
    full_op(2'b10, 32'h0000_0007, 32'hFFFF_FFFE);
    full_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    full_op(2'b11, 32'hFFFF_FFF9, 32'h0000_0002);
    full_op(2'b10, 32'hFFFF_FF00, 32'h0);
    full_op(2'b11, 32'h1234_5678, 32'h0);

    // R9 stall during run, mf_data select
    start_op(2'b01, 32'd6, 32'd7);
    mf_req = 1'b1;
    #1 chk("R9 stall while busy", 32'(stall), 1);
    wait_done(cyc);
    #1 chk("R9 stall after done", 32'(stall), 0);
    read_hl(h, l);
    chk("R9 mf LO", l, 32'd42); chk("R9 mf HI", h, 0);
    mf_req = 1'b0;

    // R8 command during run ignored; R11 HI/LO hold during run
    start_op(2'b01, 32'd100, 32'd3);
    op_valid = 1'b1; op_kind = 2'b10; op_a = 32'd99; op_b = 32'd5;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    read_hl(h, l);
    chk("R11 HI held", h, 0); chk("R11 LO held", l, 32'd42);
    wait_done(cyc);
    chk("R8 busy length", 32'(cyc), 32'd29);
    read_hl(h, l);
    chk("R8 LO unaffected", l, 32'd300); chk("R8 HI unaffected", h, 0);

    // R10 idle writes
    move_to(1'b1, 32'hCAFE_0001);
    read_hl(h, l);
    chk("R10 HI write", h, 32'hCAFE_0001); chk("R10 LO kept", l, 32'd300);
    move_to(1'b0, 32'hBEEF_0002);
    read_hl(h, l);
    chk("R10 LO write", l, 32'hBEEF_0002); chk("R10 HI kept", h, 32'hCAFE_0001);

    // R10 abort
    start_op(2'b00, 32'd5, 32'd5);
    repeat (5) @(negedge clk);
    move_to(1'b1, 32'h5A5A_A5A5);
    chk("R10 abort busy", 32'(busy), 0);
    repeat (40) @(negedge clk);
    read_hl(h, l);
    chk("R10 abort HI kept", h, 32'h5A5A_A5A5);
    chk("R10 abort LO untouched", l, 32'hBEEF_0002);

    // R8 command with move-to same cycle ignored
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'b01; op_a = 32'd2; op_b = 32'd2;
    mt_req = 1'b1; mt_sel = 1'b0; mt_data = 32'h0000_0777;
    @(negedge clk);
    op_valid = 1'b0; mt_req = 1'b0;
    chk("R8 no start with move-to", 32'(busy), 0);
    read_hl(h, l);
    chk("R8 move-to LO", l, 32'h777); chk("R8 HI kept", h, 32'h5A5A_A5A5);

    // random
    for (int i = 0; i < 60; i++) begin
      k = 2'($urandom_range(0, 3));
      a = $urandom;
      b = $urandom;
      case ($urandom_range(0, 7))
        0: b = 0;
        1: a = 32'h8000_0000;
        2: b = 32'hFFFF_FFFF;
        3: b = 32'($urandom_range(1, 9));
        default: ;
      endcase
      full_op(k, a, b);
    end
    e = model(2'b00, 32'd3, 32'd4);
    full_op(2'b00, 32'd3, 32'd4);
    read_hl(h, l);
    chk("R2 final", l, e[31:0]);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule